// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter with Signed Range Flags

This block moves a 16-bit word by any distance from 0 to 15 bit positions in a single combinational pass. One datapath serves three kinds of shift: logical, arithmetic and rotate. A separate direction input selects left or right. The distance is a 4-bit binary amount. Each amount bit enables one stage of a cascade whose stages move the word by 8, 4, 2 and 1 positions.

When the word is treated as a two's-complement number and shifted left arithmetically, the true product may not fit in 16 bits. The block then raises one of two flags. Overflow means a non-negative value grew past the largest positive number. Underflow means a negative value fell below the most negative number. The shifted word is always produced, whether or not a flag is set. There is no register and no handshake in the block: the outputs follow the inputs within the same cycle, and the surrounding pipeline decides when to sample them.

Top module: `multimode_shifter`

## Requirements
- R1: With an amount of 0, the output equals the input in every kind and direction.
- R2: In logical mode (kind 2'b00) with direction left (`to_left`=1), the output equals the input moved up by the amount. Bits leaving the MSB end are lost and zeros enter at the LSB end.
- R3: In logical mode with direction right (`to_left`=0), zeros enter at the MSB end and bits leaving the LSB end are lost.
- R4: In arithmetic mode (kind 2'b01) with direction right, every vacated upper position takes a copy of input bit 15. The result is the floor of the signed input divided by 2^amount, so 16'h8000 shifted by 15 gives 16'hFFFF.
- R5: In arithmetic mode with direction left, the output word is identical to the logical left result.
- R6: In rotate mode (kind 2'b10), bits leaving one end re-enter at the other end in either direction, so the number of ones is preserved.
- R7: `ovf_flag` is 1 exactly when the mode is arithmetic left with a non-zero amount, input bit 15 is 0, and input × 2^amount exceeds 32767. For example, 16'h4000 shifted left by 1 sets it.
- R8: `unf_flag` is 1 exactly when the mode is arithmetic left with a non-zero amount, input bit 15 is 1, and input × 2^amount is below -32768. For example, 16'hBFFF shifted left by 1 sets it, while 16'hC000 shifted left by 1 does not.
- R9: Both flags are 0 for logical, rotate and right shifts and for a zero amount, and the two flags are never 1 together.
- R10: Kind 2'b11 is reserved and behaves exactly like logical mode, with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 16 | Word to be shifted |
| shamt | input | 4 | Shift distance, 0 to 15 |
| kind | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 reserved (logical) |
| to_left | input | 1 | 1 shifts toward the MSB, 0 toward the LSB |
| data_out | output | 16 | Shifted word |
| ovf_flag | output | 1 | Arithmetic left result above the largest positive value |
| unf_flag | output | 1 | Arithmetic left result below the most negative value |

## Verification
The checker samples the inputs and outputs after the logic has settled. It only evaluates once every input carries a known 0 or 1 value, so it assumes the inputs are never left floating. The bench follows this rule: it drives every input from time zero, changes them half a clock period away from the sampling point, and reads the outputs one nanosecond after each change. Amounts are swept exhaustively over every kind and direction, with random data from a fixed seed. Directed words sit right at the flag boundaries (16'h4000, 16'h3FFF, 16'hC000, 16'hBFFF, 16'h8000, 16'h7FFF) to cover the edges that random data rarely reaches.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  // Shift kind codes carried on the kind input
  typedef enum logic [1:0] {
    KIND_LOGIC = 2'b00,
    KIND_ARITH = 2'b01,
    KIND_ROT   = 2'b10,
    KIND_RSVD  = 2'b11
  } shift_kind_e;

endpackage

// File: rtl/shift_stage.sv
// One fixed-distance stage of the log chain, always shifting toward bit 0.
module shift_stage #(
  parameter int WIDTH = 16,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             en,
  input  logic             rotate,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] moved;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (i + DIST < WIDTH) begin : g_inside
        assign moved[i] = din[i + DIST];
      end else begin : g_edge
        assign moved[i] = rotate ? din[i + DIST - WIDTH] : fill;
      end
    end
  endgenerate

  assign dout = en ? moved : din;

endmodule

// File: rtl/range_detect.sv
// Signed range check for arithmetic left shifts: the top shamt+1 bits
// must all match the sign bit for the product to fit.
module range_detect #(
  parameter int WIDTH = 16,
  parameter int AMT_W = 4
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] shamt,
  input  logic             active,
  output logic             ovf,
  output logic             unf
);

  logic [WIDTH-1:0] in_window;
  logic [WIDTH-1:0] differs;
  logic             sign;
  logic             lost;

  assign sign = din[WIDTH-1];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_win
      localparam int DEPTH = WIDTH - 1 - i;
      assign in_window[i] = (int'(shamt) >= DEPTH);
      assign differs[i]   = din[i] ^ sign;
    end
  endgenerate

  assign lost = |(in_window & differs);

  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    if (active && (shamt != '0) && lost) begin
      ovf = ~sign;
      unf = sign;
    end
  end

endmodule

// File: rtl/multimode_shifter.sv
module multimode_shifter #(
  parameter int WIDTH = 16,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] shamt,
  input  logic [1:0]       kind,
  input  logic             to_left,
  output logic [WIDTH-1:0] data_out,
  output logic             ovf_flag,
  output logic             unf_flag
);
  import shifter_pkg::*;

  localparam int STAGES = AMT_W;

  logic                          is_arith;
  logic                          is_rot;
  logic                          fill_bit;
  logic [WIDTH-1:0]              facing;
  logic [STAGES:0][WIDTH-1:0]    chain;

  assign is_arith = (kind == KIND_ARITH);
  assign is_rot   = (kind == KIND_ROT);
  // Only an arithmetic right shift pulls in copies of the sign bit
  assign fill_bit = is_arith & ~to_left & data_in[WIDTH-1];

  // Mirror the word for left shifts so every stage moves toward bit 0
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_mirror_in
      assign facing[i] = to_left ? data_in[WIDTH-1-i] : data_in[i];
    end
  endgenerate

  assign chain[0] = facing;

  // Largest distance first: 8, 4, 2, 1 for the default width
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      localparam int BIT = STAGES - 1 - s;
      shift_stage #(
        .WIDTH (WIDTH),
        .DIST  (1 << BIT)
      ) u_stage (
        .din    (chain[s]),
        .en     (shamt[BIT]),
        .rotate (is_rot),
        .fill   (fill_bit),
        .dout   (chain[s+1])
      );
    end
  endgenerate

  generate
    for (i = 0; i < WIDTH; i++) begin : g_mirror_out
      assign data_out[i] = to_left ? chain[STAGES][WIDTH-1-i] : chain[STAGES][i];
    end
  endgenerate

  range_detect #(
    .WIDTH (WIDTH),
    .AMT_W (AMT_W)
  ) u_range (
    .din    (data_in),
    .shamt  (shamt),
    .active (is_arith & to_left),
    .ovf    (ovf_flag),
    .unf    (unf_flag)
  );

endmodule

// File: rtl/shifter_checker.sv
module shifter_checker #(
  parameter int WIDTH = 16,
  parameter int AMT_W = 4
) (
  input logic [WIDTH-1:0] data_in,
  input logic [AMT_W-1:0] shamt,
  input logic [1:0]       kind,
  input logic             to_left,
  input logic [WIDTH-1:0] data_out,
  input logic             ovf_flag,
  input logic             unf_flag
);

  always_comb begin
    if (!$isunknown({data_in, shamt, kind, to_left, data_out, ovf_flag, unf_flag})) begin
      p_zero_amount_r1: assert (shamt != '0 || data_out == data_in)
        else $error("zero amount changed the word");
      p_logic_left_fill_r2: assert (!(kind != 2'b01 && kind != 2'b10 && to_left && shamt != '0) || data_out[0] == 1'b0)
        else $error("left shift did not fill LSB with zero");
      p_logic_right_fill_r3: assert (!(kind[0] == kind[1] && !to_left && shamt != '0) || data_out[WIDTH-1] == 1'b0)
        else $error("logical right did not fill MSB with zero");
      p_arith_right_sign_r4: assert (!(kind == 2'b01 && !to_left) || data_out[WIDTH-1] == data_in[WIDTH-1])
        else $error("arithmetic right lost the sign");
      p_rotate_keeps_ones_r6: assert (kind != 2'b10 || $countones(data_out) == $countones(data_in))
        else $error("rotate changed the number of ones");
      p_ovf_sign_r7: assert (!ovf_flag || data_in[WIDTH-1] == 1'b0)
        else $error("overflow raised for a negative input");
      p_unf_sign_r8: assert (!unf_flag || data_in[WIDTH-1] == 1'b1)
        else $error("underflow raised for a non-negative input");
      p_no_overflow_r9: assert ((kind == 2'b01 && to_left && shamt != '0) || !(ovf_flag || unf_flag))
        else $error("flag raised outside arithmetic left");
      p_flags_exclusive_r9: assert (!(ovf_flag && unf_flag))
        else $error("both flags raised");
    end
  end

endmodule

bind multimode_shifter shifter_checker #(
  .WIDTH (WIDTH),
  .AMT_W (AMT_W)
) u_shifter_checker (
  .data_in  (data_in),
  .shamt    (shamt),
  .kind     (kind),
  .to_left  (to_left),
  .data_out (data_out),
  .ovf_flag (ovf_flag),
  .unf_flag (unf_flag)
);

// File: tb/test_multimode_shifter.sv
`timescale 1ns/1ps
module test_multimode_shifter;

  logic        clk = 1'b0;
  logic [15:0] data_in = '0;
  logic [3:0]  shamt = '0;
  logic [1:0]  kind = '0;
  logic        to_left = 1'b0;
  logic [15:0] data_out;
  logic        ovf_flag;
  logic        unf_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  multimode_shifter i_multimode_shifter (
    .data_in  (data_in),
    .shamt    (shamt),
    .kind     (kind),
    .to_left  (to_left),
    .data_out (data_out),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
  );

  function automatic logic [15:0] exp_word(input logic [15:0] d, input int a,
                                           input logic [1:0] k, input logic l);
    logic [31:0] dd;
    dd = {d, d};
    if (a == 0) return d;
    if (k == 2'b10) begin
      if (l) begin
        dd = dd << a;
        return dd[31:16];
      end
      dd = dd >> a;
      return dd[15:0];
    end
    if (l) return d << a;
    if (k == 2'b01) return 16'($signed(d) >>> a);
    return d >> a;
  endfunction

  function automatic logic [1:0] exp_flags(input logic [15:0] d, input int a,
                                           input logic [1:0] k, input logic l);
    longint v;
    if (!(k == 2'b01 && l && a != 0)) return 2'b00;
    v = longint'($signed(d)) * (longint'(1) << a);
    if (v > 32767)  return 2'b10;
    if (v < -32768) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string word_tag(input int a, input logic [1:0] k, input logic l);
    if (a == 0)     return "R1";
    if (k == 2'b11) return "R10";
    if (k == 2'b10) return "R6";
    if (k == 2'b01) return l ? "R5" : "R4";
    return l ? "R2" : "R3";
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (data %h amt %0d kind %b left %b)",
               tag, got, exp, data_in, shamt, kind, to_left);
    end
  endtask

  task automatic apply(input logic [15:0] d, input int a, input logic [1:0] k, input logic l);
    logic [1:0] f;
    @(negedge clk);
    data_in = d;
    shamt   = 4'(a);
    kind    = k;
    to_left = l;
    #1;
    f = exp_flags(d, a, k, l);
    check(word_tag(a, k, l), data_out, exp_word(d, a, k, l));
    check((k == 2'b01 && l && a != 0) ? "R7" : "R9", 16'(ovf_flag), 16'(f[1]));
    check((k == 2'b01 && l && a != 0) ? "R8" : "R9", 16'(unf_flag), 16'(f[0]));
    if (ovf_flag && unf_flag) check("R9", 16'd1, 16'd0);
  endtask

  initial begin : watchdog
    #500us;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    logic [15:0] r;
    seed = 32'h1d2c_3b4a;
    void'($urandom(seed));
    // Idle state: all-zero inputs give an all-zero word and no flags (R1)
    #1;
    check("R1", data_out, 16'h0000);
    check("R9", 16'({ovf_flag, unf_flag}), 16'h0000);

    // Directed boundary cases
    apply(16'h4000, 1, 2'b01, 1'b1);   // R7 overflow
    apply(16'h3FFF, 1, 2'b01, 1'b1);   // R7 fits
    apply(16'h3FFF, 2, 2'b01, 1'b1);   // R7 overflow
    apply(16'hBFFF, 1, 2'b01, 1'b1);   // R8 underflow
    apply(16'hC000, 1, 2'b01, 1'b1);   // R8 exactly most negative
    apply(16'h8000, 15, 2'b01, 1'b0);  // R4 all ones
    apply(16'hFFFB, 1, 2'b01, 1'b0);   // R4 floor of -5/2
    apply(16'h7FFF, 15, 2'b01, 1'b1);  // R7
    apply(16'hFFFF, 15, 2'b01, 1'b1);  // R8 -1 * 2^15 fits
    apply(16'h0001, 15, 2'b01, 1'b1);  // R7 2^15 overflows
    apply(16'h8001, 1, 2'b10, 1'b1);   // R6 wrap left
    apply(16'h8001, 1, 2'b10, 1'b0);   // R6 wrap right
    apply(16'hCB00, 3, 2'b11, 1'b0);   // R10 logical right
    apply(16'hCB00, 3, 2'b11, 1'b1);   // R10 logical left
    apply(16'h4000, 1, 2'b00, 1'b1);   // R9 no flag in logical

    // Exhaustive amounts over every kind and direction, random data
    for (int rep = 0; rep < 20; rep++) begin
      for (int k = 0; k < 4; k++) begin
        for (int l = 0; l < 2; l++) begin
          for (int a = 0; a < 16; a++) begin
            r = 16'($urandom);
            if (rep == 1) r = {1'b0, r[14:0]};
            if (rep == 2) r = {1'b1, r[14:0]};
            if (rep == 3) r = 16'h0000;
            if (rep == 4) r = 16'hFFFF;
            apply(r, a, 2'(k), 1'(l));
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule